// File: doc/BRIEF.md
# Cascadable Strobe-Handshake FIFO

This block is a 64-word first-in first-out buffer whose word width is a parameter (4 or 5 bits, default 5). A writer places a word on `data_in` and raises `shift_in`. A reader takes the word shown on `data_out` and raises `shift_out`. Two registered flags carry the handshake. `in_ready` says a word can be taken. `out_ready` says `data_out` holds a valid word. Both strobes are synchronous to `clk`. Each high period of a strobe moves at most one word, and this is what makes the strobes edge-like.

A word written into an empty buffer does not appear at once. It falls through to the output after `LAT` clock cycles (default 2). After every accepted transfer, the flag on that side dips low for one cycle before it may rise again. Because of that dip, identical instances can be chained for depth with no glue logic. The upstream `out_ready` drives the downstream `shift_in`, the upstream `data_out` drives the downstream `data_in`, and the downstream `in_ready` drives the upstream `shift_out`. For wider words, instances are placed side by side, and their ready flags are ANDed outside the block. An output-enable input qualifies the data outputs. When it is low, `data_out` reads zero and `data_drv` reports that the outputs are not being driven.

Top module: `casc_fifo`

## Requirements
- R1: `rst` is a synchronous, active-high reset. After any clock edge that samples it high, `out_ready` is 0 and `in_ready` is 1, and every stored word is discarded.
- R2: Words leave in exactly the order they were accepted. While `out_ready` is high and no shift-out is accepted, `data_out` holds its value.
- R3: A word is accepted into an empty buffer at clock edge E. `out_ready` is 0 after edges E through E+LAT-1, and it is 1 after edge E+LAT, with that word on `data_out`.
- R4: A shift-out is accepted at edge P. `out_ready` is 0 for the cycle after P. If a further word has already fallen through, `out_ready` is 1 after edge P+1 and that word is on `data_out`.
- R5: `in_ready` is 0 for the cycle after each accepted shift-in. It stays 0 for as long as 64 words are held.
- R6: A shift-in strobe that rises and falls while `in_ready` is 0 transfers nothing. The one exception is the case in R9.
- R7: A shift-out strobe while `out_ready` is 0 transfers nothing. It does not disturb the words that are written later.
- R8: Each high period of a strobe transfers at most one word, however long the strobe stays high. A strobe that is already high is served in the first cycle in which its ready flag is 1.
- R9: A shift-in and a shift-out may be accepted at the same edge on a full buffer. In that case the buffer stays full, with `in_ready` at 0, and the new word takes the last place in the order.
- R10: With `out_en` = 0, `data_out` is all zeros and `data_drv` is 0. With `out_en` = 1, `data_drv` is 1 and `data_out` shows the held word. The enable never changes the stored contents.
- R11: Two instances chained as described above behave as one buffer that delivers every word in order. This includes the case where the downstream instance is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_in | input | 1 | Write strobe, served once per high period |
| data_in | input | WIDTH | Word to be written |
| in_ready | output | 1 | Room available; dips for one cycle after each accepted write |
| shift_out | input | 1 | Read strobe, served once per high period |
| out_ready | output | 1 | Valid word on data_out; dips for one cycle after each accepted read |
| out_en | input | 1 | Output enable qualifier |
| data_out | output | WIDTH | Oldest stored word, zero when not enabled |
| data_drv | output | 1 | High when data_out is being driven |

## Verification
Mixed sequences of writes and reads are taken from a vector table. They separate true first-in first-out ordering from a stack or from a pointer that skips a place. Single writes into an empty buffer are sampled in every cycle of the fall-through window, which exposes an off-by-one latency or a missing one-cycle dip on either flag. A full buffer is then probed three ways: with a blocked write, with a simultaneous write and read, and with a full drain. This tells an ignored write apart from one that overwrites or overflows. A long strobe tells single service apart from repeated capture. A two-instance chain pushed past the downstream capacity shows whether a held strobe is served the moment room appears.

// File: rtl/casc_fifo_pkg.sv
`timescale 1ns/1ps
package casc_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 64;
  localparam int unsigned DEF_WIDTH = 5;
  localparam int unsigned DEF_LAT   = 2;

  // bits needed to hold every value from 0 up to n
  function automatic int unsigned count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // bits needed to address n entries
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/casc_fifo_strobe.sv
`timescale 1ns/1ps
// Turns a level strobe into a request that can be served once per high period.
module casc_fifo_strobe (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic taken,
  output logic req
);
  logic served_q;

  assign req = strobe & ~served_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      served_q <= 1'b0;
    end else begin
      // stays set while the strobe is held, clears once it drops
      served_q <= strobe & (served_q | taken);
    end
  end

  // R8: a served strobe raises no further request in its high period
  p_one_per_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    taken |=> !req);
endmodule

// File: rtl/casc_fifo_store.sv
`timescale 1ns/1ps
// Word storage: one write port, registered read of the head entry.
module casc_fifo_store #(
  parameter int unsigned WIDTH = casc_fifo_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = casc_fifo_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_adv,
  output logic [WIDTH-1:0] rd_word
);
  localparam int unsigned AW = casc_fifo_pkg::addr_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // no reset on the array or its read register, so block RAM fits
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr] <= wr_data;
    end
    rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= bump(wr_ptr);
      end
      if (rd_adv) begin
        rd_ptr <= bump(rd_ptr);
      end
    end
  end
endmodule

// File: rtl/casc_fifo_flags.sv
`timescale 1ns/1ps
// Occupancy, fall-through maturity tracking and the two ready flags.
module casc_fifo_flags #(
  parameter int unsigned DEPTH = casc_fifo_pkg::DEF_DEPTH,
  parameter int unsigned LAT   = casc_fifo_pkg::DEF_LAT
) (
  input  logic clk,
  input  logic rst,
  input  logic push_req,
  input  logic pop_req,
  output logic push_ok,
  output logic pop_ok,
  output logic ir_q,
  output logic or_q
);
  localparam int unsigned CW = casc_fifo_pkg::count_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  rdy_q, rdy_d;
  logic [LAT-1:0] dl_q, dl_d;
  logic           full;
  logic           matured;

  assign full    = (cnt_q == FULL_CNT);
  assign pop_ok  = pop_req & or_q;
  // a full buffer takes a write only alongside an accepted read
  assign push_ok = push_req & (ir_q | (full & pop_ok));
  assign matured = dl_q[LAT-1];

  generate
    if (LAT == 1) begin : g_lat_one
      assign dl_d = push_ok;
    end else begin : g_lat_many
      assign dl_d = {dl_q[LAT-2:0], push_ok};
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    rdy_d = rdy_q + CW'(matured) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= '0;
      dl_q  <= '0;
      ir_q  <= 1'b1;
      or_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      dl_q  <= dl_d;
      ir_q  <= ~push_ok & (cnt_d < FULL_CNT);
      or_q  <= ~pop_ok & (rdy_d != '0);
    end
  end

  // R1: reset leaves an empty buffer with room and no output word
  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> (ir_q && !or_q && cnt_q == '0));

  // R5: occupancy never exceeds the depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  // R5: in_ready dips after every accepted write
  p_ir_dip_r5: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> !ir_q);

  // R4: out_ready dips after every accepted read
  p_or_dip_r4: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> !or_q);

  // R3: a write into an empty buffer is not visible on the next cycle
  p_fall_through_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && push_ok) |=> !or_q);

  // R7: out_ready never claims a word in an empty buffer
  p_or_has_word_r7: assert property (@(posedge clk) disable iff (rst)
    or_q |-> cnt_q != '0);

  // R9: a write and a read together on a full buffer keep it full
  p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push_ok && pop_ok) |=> (cnt_q == FULL_CNT && !ir_q));
endmodule

// File: rtl/casc_fifo.sv
`timescale 1ns/1ps
module casc_fifo #(
  parameter int unsigned WIDTH  = casc_fifo_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH  = casc_fifo_pkg::DEF_DEPTH,
  parameter int unsigned LAT    = casc_fifo_pkg::DEF_LAT,
  parameter bit          USE_OE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  input  logic             out_en,
  output logic [WIDTH-1:0] data_out,
  output logic             data_drv
);
  logic             si_req;
  logic             so_req;
  logic             push_ok;
  logic             pop_ok;
  logic             ir_flag;
  logic             or_flag;
  logic             drive;
  logic [WIDTH-1:0] word_q;

  casc_fifo_strobe u_in_strobe (
    .clk    (clk),
    .rst    (rst),
    .strobe (shift_in),
    .taken  (push_ok),
    .req    (si_req)
  );

  casc_fifo_strobe u_out_strobe (
    .clk    (clk),
    .rst    (rst),
    .strobe (shift_out),
    .taken  (pop_ok),
    .req    (so_req)
  );

  casc_fifo_flags #(
    .DEPTH (DEPTH),
    .LAT   (LAT)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .push_req (si_req),
    .pop_req  (so_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .ir_q     (ir_flag),
    .or_q     (or_flag)
  );

  casc_fifo_store #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_ok),
    .wr_data (data_in),
    .rd_adv  (pop_ok),
    .rd_word (word_q)
  );

  generate
    if (USE_OE) begin : g_oe
      assign drive = out_en;
    end else begin : g_no_oe
      logic unused_oe;
      assign unused_oe = out_en;
      assign drive     = 1'b1;
    end
  endgenerate

  assign in_ready  = ir_flag;
  assign out_ready = or_flag;
  assign data_drv  = drive;
  assign data_out  = drive ? word_q : '0;

  // R2: the presented word holds until it is read
  p_hold_word_r2: assert property (@(posedge clk) disable iff (rst)
    (or_flag && !pop_ok) |=> $stable(word_q));
endmodule

// File: tb/casc_fifo_bench.sv
`timescale 1ns/1ps
module casc_fifo_bench;
  localparam int W = 5;
  localparam int D = 64;
  localparam int L = 2;
  localparam int NV = 12;
  // bit 5: 1 = write the word, 0 = read and expect the word
  localparam logic [5:0] VEC [NV] = '{
    6'h23, 6'h3C, 6'h03, 6'h2A, 6'h35, 6'h1C,
    6'h0A, 6'h3F, 6'h15, 6'h1F, 6'h20, 6'h00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic si, so, oe, ir, orr, drv;
  logic [W-1:0] din, dout;
  logic up_si, up_ir, up_or, up_drv, dn_so, dn_ir, dn_or, dn_drv;
  logic [W-1:0] up_din, up_dout, dn_dout;

  casc_fifo #(.WIDTH(W), .DEPTH(D), .LAT(L), .USE_OE(1'b1)) u_casc_fifo (
    .clk(clk), .rst(rst), .shift_in(si), .data_in(din), .in_ready(ir),
    .shift_out(so), .out_ready(orr), .out_en(oe), .data_out(dout), .data_drv(drv)
  );

  casc_fifo #(.WIDTH(W), .DEPTH(D), .LAT(L), .USE_OE(1'b1)) u_casc_fifo_up (
    .clk(clk), .rst(rst), .shift_in(up_si), .data_in(up_din), .in_ready(up_ir),
    .shift_out(dn_ir), .out_ready(up_or), .out_en(1'b1), .data_out(up_dout),
    .data_drv(up_drv)
  );

  casc_fifo #(.WIDTH(W), .DEPTH(D), .LAT(L), .USE_OE(1'b1)) u_casc_fifo_dn (
    .clk(clk), .rst(rst), .shift_in(up_or), .data_in(up_dout), .in_ready(dn_ir),
    .shift_out(dn_so), .out_ready(dn_or), .out_en(1'b1), .data_out(dn_dout),
    .data_drv(dn_drv)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] wf(input int i);
    return W'((i * 7 + 3) % 32);
  endfunction

  function automatic logic [W-1:0] wc(input int i);
    return W'((i * 11 + 5) % 32);
  endfunction

  task automatic push(input logic [W-1:0] w);
    int t = 0;
    while (!ir && t < 20) begin step(); t++; end
    if (!ir) chk("R5 in_ready never returned", 32'(ir), 32'd1);
    din = w; si = 1'b1; step(); si = 1'b0; step();
  endtask

  task automatic pop(input logic [W-1:0] exp, input string req);
    int t = 0;
    while (!orr && t < 20) begin step(); t++; end
    if (!orr) chk({req, " out_ready"}, 32'(orr), 32'd1);
    chk(req, 32'(dout), 32'(exp));
    so = 1'b1; step(); so = 1'b0; step();
  endtask

  task automatic push_up(input logic [W-1:0] w);
    int t = 0;
    while (!up_ir && t < 20) begin step(); t++; end
    if (!up_ir) chk("R11 upstream in_ready", 32'(up_ir), 32'd1);
    up_din = w; up_si = 1'b1; step(); up_si = 1'b0; step();
  endtask

  task automatic pop_dn(input logic [W-1:0] exp, input string req);
    int t = 0;
    while (!dn_or && t < 20) begin step(); t++; end
    if (!dn_or) chk({req, " out_ready"}, 32'(dn_or), 32'd1);
    chk(req, 32'(dn_dout), 32'(exp));
    dn_so = 1'b1; step(); dn_so = 1'b0; step();
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    si = 0; so = 0; din = '0; oe = 1'b1;
    up_si = 0; up_din = '0; dn_so = 0;
    step(3);
    // R1: reset state
    chk("R1 out_ready after reset", 32'(orr), 32'd0);
    chk("R1 in_ready after reset", 32'(ir), 32'd1);
    rst = 1'b0;
    step(2);
    chk("R1 out_ready idle", 32'(orr), 32'd0);
    chk("R1 in_ready idle", 32'(ir), 32'd1);

    // R2: table of interleaved writes and reads
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][5]) push(VEC[k][W-1:0]);
      else pop(VEC[k][W-1:0], "R2 order");
    end

    // R3 and R5: fall-through window and in_ready dip
    step(2);
    din = 5'h11; si = 1'b1; step();
    chk("R5 in_ready dip", 32'(ir), 32'd0);
    chk("R3 out_ready too early (E)", 32'(orr), 32'd0);
    si = 1'b0; step();
    chk("R3 out_ready too early (E+1)", 32'(orr), 32'd0);
    chk("R5 in_ready back", 32'(ir), 32'd1);
    step();
    chk("R3 out_ready at E+LAT", 32'(orr), 32'd1);
    chk("R3 data at E+LAT", 32'(dout), 32'h11);
    pop(5'h11, "R2 single word");

    // R4: dip after a read, next word follows
    push(5'h06); push(5'h19); step(4);
    chk("R4 head word", 32'(dout), 32'h06);
    so = 1'b1; step();
    chk("R4 out_ready dip", 32'(orr), 32'd0);
    so = 1'b0; step();
    chk("R4 out_ready returns", 32'(orr), 32'd1);
    chk("R4 next word", 32'(dout), 32'h19);
    pop(5'h19, "R4 second word");
    step(3);
    chk("R4 empty after drain", 32'(orr), 32'd0);

    // R7: read on empty is ignored
    so = 1'b1; step(); so = 1'b0; step(2);
    chk("R7 out_ready stays low", 32'(orr), 32'd0);
    push(5'h0D);
    pop(5'h0D, "R7 later word intact");
    step(3);
    chk("R7 no phantom word", 32'(orr), 32'd0);

    // R8: long strobe moves one word
    din = 5'h12; si = 1'b1; step(2);
    din = 5'h0B; step(3);
    si = 1'b0; step();
    pop(5'h12, "R8 first capture");
    step(4);
    chk("R8 single word only", 32'(orr), 32'd0);

    // R10: output enable
    push(5'h1E); step(4);
    oe = 1'b0; #1;
    chk("R10 data gated", 32'(dout), 32'h0);
    chk("R10 drive low", 32'(drv), 32'd0);
    oe = 1'b1; #1;
    chk("R10 data shown", 32'(dout), 32'h1E);
    chk("R10 drive high", 32'(drv), 32'd1);
    pop(5'h1E, "R10 word retained");

    // R1: reset while holding words
    push(5'h07); push(5'h08); step(4);
    rst = 1'b1; step();
    chk("R1 out_ready after mid reset", 32'(orr), 32'd0);
    chk("R1 in_ready after mid reset", 32'(ir), 32'd1);
    rst = 1'b0; step(4);
    chk("R1 contents dropped", 32'(orr), 32'd0);
    push(5'h09);
    pop(5'h09, "R1 restart");

    // R5, R6, R9: full buffer
    for (int i = 0; i < D; i++) push(wf(i));
    chk("R5 in_ready low when full", 32'(ir), 32'd0);
    step(3);
    chk("R5 in_ready stays low", 32'(ir), 32'd0);
    din = 5'h1F; si = 1'b1; step(); si = 1'b0; step();
    chk("R6 blocked write leaves full", 32'(ir), 32'd0);
    chk("R9 head before swap", 32'(dout), 32'(wf(0)));
    din = 5'h1A; si = 1'b1; so = 1'b1; step();
    si = 1'b0; so = 1'b0;
    chk("R9 in_ready after swap", 32'(ir), 32'd0);
    step();
    chk("R9 still full", 32'(ir), 32'd0);
    for (int i = 1; i < D; i++) pop(wf(i), "R6 R9 drain order");
    pop(5'h1A, "R9 swapped word last");
    step(3);
    chk("R9 empty after drain", 32'(orr), 32'd0);
    chk("R9 room after drain", 32'(ir), 32'd1);

    // R11: chain of two, pushed past the downstream depth
    for (int i = 0; i < D + 6; i++) push_up(wc(i));
    for (int i = 0; i < D + 6; i++) pop_dn(wc(i), "R11 chain order");
    step(4);
    chk("R11 upstream empty", 32'(up_or), 32'd0);
    chk("R11 downstream empty", 32'(dn_or), 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule